// File: doc/BRIEF.md
# Erase-Verify Retry Sequencer

This block is a host-side controller that erases a region of a flash-like memory and then proves the erase word by word. A single request channel carries every action to a bus-cycle generator: entering the verify mode, the chosen erase, leaving the verify mode, and plain word reads. Each request is a one-cycle pulse. The generator answers each one with a one-cycle response pulse, which carries the read data for reads.

After each erase the controller polls status reads until the erase has ended. It can watch either a toggling status bit or a data-complement bit. It then reads each word of the region in turn, starting from address zero and ending at `LAST_ADDR`.

A word that does not read back as all ones is read twice more before it counts as a failure, so that a read racing the end of the erase does not cause a false rejection. A confirmed failure re-issues the erase, up to a per-word limit. The outcome is reported on `done` or `error`, and whichever is set stays set until the next start.

Top module: `evr_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `req_valid` are 0. A `start` pulse while idle clears the word address and the retry count, and the first request issued is op 0 (enter verify) at address 0.
- R2: Op codes on `req_op` are 0 enter verify, 1 erase, 2 exit verify, 3 read. Every run begins with one enter request. No read is issued before the first erase. Every erase request carries on `req_kind` the `erase_kind` value captured at start.
- R3: With `poll_toggle`=1, the end of an erase is taken when two consecutive status reads show the same value in bit 6. A single read never ends polling.
- R4: With `poll_toggle`=0, the end of an erase is taken at the first status read whose bit 7 is 1.
- R5: After polling ends, the word at the current address is read. A value of 0xFFFF moves to the next address, which is read without a new erase. Read addresses never decrease within a run.
- R6: When the word at `LAST_ADDR` passes, exactly one exit request (op 2) is issued at that address, and `done` rises after its response.
- R7: A word that reads other than 0xFFFF is read again, at most two more times. Any of the three reads returning 0xFFFF is a pass. A rejection needs all three to fail.
- R8: A rejection below the limit adds one to the retry count and re-issues the erase at the same address, with no new enter request. The retry count clears whenever the address advances, so the limit applies per word.
- R9: The `RETRY_LIMIT`-th rejection of one word ends the run with `error`, and no exit request is issued.
- R10: `done` and `error` are never both 1. Each holds until the next accepted start. A `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| erase_kind | input | 2 | Erase type passed on erase requests (0 sector, 1 block, 2 whole bank) |
| poll_toggle | input | 1 | 1: poll the toggling bit 6; 0: poll bit 7 |
| req_valid | output | 1 | One-cycle request pulse to the bus-cycle generator |
| req_op | output | 2 | Request operation code |
| req_kind | output | 2 | Erase type captured at start |
| req_addr | output | ADDR_W | Word address of the request |
| rsp_valid | input | 1 | One-cycle response pulse ending the outstanding request |
| rsp_data | input | 16 | Read data, valid with `rsp_valid` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The region verified clean |
| error | output | 1 | A word exhausted its retries |

## Verification
A request is issued in the cycle after the edge that accepts the start or the previous response. The bench therefore answers only after at least one further falling edge, and it samples `req_valid` at falling edges. `done` or `error` rises at the edge that takes the last response, so the bench waits on those outputs at falling edges and then compares the counts of enter, erase, read and exit requests it logged against counts computed by its own model of the requirements. The reference counts follow from the number of status reads due per erase, which is a closed form in the number of busy reads. After completion the outputs are sampled again five cycles later to confirm they hold.

// File: rtl/evr_pkg.sv
package evr_pkg;

    localparam int WORD_W  = 16;
    localparam int REREADS = 2;

    typedef enum logic [1:0] {
        OP_VFY_ENTER = 2'd0,
        OP_ERASE     = 2'd1,
        OP_VFY_EXIT  = 2'd2,
        OP_READ      = 2'd3
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ENTER_REQ,
        S_ENTER_WAIT,
        S_ERASE_REQ,
        S_ERASE_WAIT,
        S_POLL_REQ,
        S_POLL_WAIT,
        S_CHECK_REQ,
        S_CHECK_WAIT,
        S_EXIT_REQ,
        S_EXIT_WAIT
    } seq_state_e;

    typedef struct packed {
        logic data_bit;
        logic toggle_bit;
    } status_bits_t;

    typedef struct packed {
        logic pass;
        logic again;
        logic reject;
    } vote_t;

    function automatic logic word_clean(logic [WORD_W-1:0] w);
        return &w;
    endfunction

    function automatic status_bits_t status_of(logic [WORD_W-1:0] w);
        status_bits_t s;
        s.data_bit   = w[7];
        s.toggle_bit = w[6];
        return s;
    endfunction

    function automatic logic is_request(seq_state_e s);
        return (s == S_ENTER_REQ) || (s == S_ERASE_REQ) || (s == S_POLL_REQ) ||
               (s == S_CHECK_REQ) || (s == S_EXIT_REQ);
    endfunction

    function automatic bus_op_e op_for(seq_state_e s);
        case (s)
            S_ENTER_REQ, S_ENTER_WAIT: return OP_VFY_ENTER;
            S_ERASE_REQ, S_ERASE_WAIT: return OP_ERASE;
            S_EXIT_REQ,  S_EXIT_WAIT:  return OP_VFY_EXIT;
            default:                   return OP_READ;
        endcase
    endfunction

endpackage

// File: rtl/evr_addr_ctr.sv
module evr_addr_ctr #(
    parameter int ADDR_W    = 10,
    parameter int LAST_ADDR = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST_V = ADDR_W'(LAST_ADDR);

    assign at_last = (addr == LAST_V);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            addr <= '0;
        end else if (step && !at_last) begin
            addr <= addr + 1'b1;
        end
    end

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        addr <= LAST_V); // R5

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && !at_last) |=> (addr == $past(addr) + 1'b1)); // R5

endmodule

// File: rtl/evr_retry_ctr.sv
module evr_retry_ctr #(
    parameter int RETRY_LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic last_try
);
    localparam int RETRY_W = $clog2(RETRY_LIMIT + 1);
    localparam logic [RETRY_W-1:0] FINAL_V = RETRY_W'(RETRY_LIMIT - 1);

    logic [RETRY_W-1:0] count;

    assign last_try = (count == FINAL_V);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (bump && !last_try) begin
            count <= count + 1'b1;
        end
    end

    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
        count < RETRY_W'(RETRY_LIMIT)); // R9

    AST_RETRY_STEP: assert property (@(posedge clk) disable iff (rst)
        (bump && !clear && !last_try) |=> (count == $past(count) + 1'b1)); // R8

    AST_RETRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0)); // R8

endmodule

// File: rtl/evr_poll_judge.sv
module evr_poll_judge
    import evr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic         sample,
    input  logic         use_toggle,
    input  status_bits_t st,
    output logic         settled
);
    logic prev_tog;
    logic have_prev;

    always_comb begin
        if (use_toggle) begin
            settled = have_prev && (st.toggle_bit == prev_tog);
        end else begin
            settled = st.data_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev <= 1'b0;
            prev_tog  <= 1'b0;
        end else if (arm) begin
            have_prev <= 1'b0;
        end else if (sample) begin
            have_prev <= 1'b1;
            prev_tog  <= st.toggle_bit;
        end
    end

    AST_TOGGLE_PAIR: assert property (@(posedge clk) disable iff (rst)
        (arm && use_toggle) |=> !(sample && settled)); // R3

    AST_DATA_BIT: assert property (@(posedge clk) disable iff (rst)
        (sample && !use_toggle && !st.data_bit) |-> !settled); // R4

endmodule

// File: rtl/evr_read_vote.sv
module evr_read_vote
    import evr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              sample,
    input  logic [WORD_W-1:0] word,
    output vote_t             v
);
    localparam logic [1:0] CAP = 2'(REREADS);

    logic [1:0] attempt;
    logic       clean;

    assign clean    = word_clean(word);
    assign v.pass   = sample && clean;
    assign v.reject = sample && !clean && (attempt == CAP);
    assign v.again  = sample && !clean && (attempt != CAP);

    always_ff @(posedge clk) begin
        if (rst || arm || v.pass || v.reject) begin
            attempt <= '0;
        end else if (v.again) begin
            attempt <= attempt + 1'b1;
        end
    end

    AST_REREAD_CAP: assert property (@(posedge clk) disable iff (rst)
        attempt <= CAP); // R7

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({v.pass, v.again, v.reject})); // R7

    AST_FIRST_FAIL_RETRIES: assert property (@(posedge clk) disable iff (rst)
        (arm || v.pass) |=> !v.reject); // R7

endmodule

// File: rtl/evr_sequencer.sv
module evr_sequencer
    import evr_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int LAST_ADDR   = 7,
    parameter int RETRY_LIMIT = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        erase_kind,
    input  logic              poll_toggle,
    output logic              req_valid,
    output logic [1:0]        req_op,
    output logic [1:0]        req_kind,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              rsp_valid,
    input  logic [15:0]       rsp_data,
    output logic              busy,
    output logic              done,
    output logic              error
);
    localparam logic [ADDR_W-1:0] LAST_V = ADDR_W'(LAST_ADDR);

    seq_state_e state, nxt;
    logic       toggle_q;
    logic [1:0] kind_q;

    logic start_ok, at_last, last_try;
    logic poll_arm, poll_sample, settled;
    logic adv, bump, retry_clr;
    logic chk_sample;
    vote_t v;

    assign start_ok    = start && (state == S_IDLE);
    assign poll_arm    = (state == S_ERASE_WAIT) && rsp_valid;
    assign poll_sample = (state == S_POLL_WAIT)  && rsp_valid;
    assign chk_sample  = (state == S_CHECK_WAIT) && rsp_valid;
    assign adv         = v.pass && !at_last;
    assign bump        = v.reject && !last_try;
    assign retry_clr   = start_ok || adv;

    evr_addr_ctr #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_addr (
        .clk(clk), .rst(rst), .clear(start_ok), .step(adv),
        .addr(req_addr), .at_last(at_last)
    );

    evr_retry_ctr #(.RETRY_LIMIT(RETRY_LIMIT)) u_retry (
        .clk(clk), .rst(rst), .clear(retry_clr), .bump(bump), .last_try(last_try)
    );

    evr_poll_judge u_poll (
        .clk(clk), .rst(rst), .arm(poll_arm), .sample(poll_sample),
        .use_toggle(toggle_q), .st(status_of(rsp_data)), .settled(settled)
    );

    evr_read_vote u_vote (
        .clk(clk), .rst(rst), .arm(start_ok), .sample(chk_sample),
        .word(rsp_data), .v(v)
    );

    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:       if (start)     nxt = S_ENTER_REQ;
            S_ENTER_REQ:                 nxt = S_ENTER_WAIT;
            S_ENTER_WAIT: if (rsp_valid) nxt = S_ERASE_REQ;
            S_ERASE_REQ:                 nxt = S_ERASE_WAIT;
            S_ERASE_WAIT: if (rsp_valid) nxt = S_POLL_REQ;
            S_POLL_REQ:                  nxt = S_POLL_WAIT;
            S_POLL_WAIT: begin
                if (rsp_valid) nxt = settled ? S_CHECK_REQ : S_POLL_REQ;
            end
            S_CHECK_REQ:                 nxt = S_CHECK_WAIT;
            S_CHECK_WAIT: begin
                if (v.pass)        nxt = at_last ? S_EXIT_REQ : S_CHECK_REQ;
                else if (v.again)  nxt = S_CHECK_REQ;
                else if (v.reject) nxt = last_try ? S_IDLE : S_ERASE_REQ;
            end
            S_EXIT_REQ:                  nxt = S_EXIT_WAIT;
            S_EXIT_WAIT:  if (rsp_valid) nxt = S_IDLE;
            default:                     nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            done     <= 1'b0;
            error    <= 1'b0;
            toggle_q <= 1'b0;
            kind_q   <= '0;
        end else begin
            state <= nxt;
            if (start_ok) begin
                done     <= 1'b0;
                error    <= 1'b0;
                toggle_q <= poll_toggle;
                kind_q   <= erase_kind;
            end else if (state == S_EXIT_WAIT && rsp_valid) begin
                done <= 1'b1;
            end else if (v.reject && last_try) begin
                error <= 1'b1;
            end
        end
    end

    assign busy      = (state != S_IDLE);
    assign req_valid = is_request(state);
    assign req_op    = op_for(state);
    assign req_kind  = kind_q;

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (req_valid && req_op == 2'd0 && req_addr == '0)); // R1

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && error)); // R10

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R10

    AST_ERROR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (error && !start) |=> error); // R10

    AST_EXIT_AT_LAST: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd2) |-> (req_addr == LAST_V)); // R6

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> (req_kind == $past(req_kind))); // R10

endmodule

// File: tb/evr_sequencer_test.sv
module evr_sequencer_test;
    localparam int ADDR_W = 10;
    localparam int LAST   = 7;
    localparam int NW     = LAST + 1;
    localparam int LIMIT  = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [1:0] erase_kind = 2'd0;
    logic poll_toggle = 1'b0;
    logic req_valid;
    logic [1:0] req_op, req_kind;
    logic [ADDR_W-1:0] req_addr;
    logic rsp_valid = 1'b0;
    logic [15:0] rsp_data = 16'h0;
    logic busy, done, error;

    always #4 clk = ~clk;

    evr_sequencer #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST), .RETRY_LIMIT(LIMIT)) uut (
        .clk(clk), .rst(rst), .start(start), .erase_kind(erase_kind),
        .poll_toggle(poll_toggle), .req_valid(req_valid), .req_op(req_op),
        .req_kind(req_kind), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .busy(busy), .done(done), .error(error)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    int need [NW];
    int erase_cnt, busy_left, spur_left, b_cfg;
    logic tog;
    int n_enter, n_erase, n_exit, n_read, last_rd, exit_addr;
    bit first_seen, first_ok, order_bad, kind_bad, addr_bad;
    logic [1:0] kind_exp;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int poll_reads(input bit tmode, input int b);
        if (!tmode) return b + 1;
        if (b == 0) return 2;
        return (b % 2 == 1) ? b + 2 : b + 1;
    endfunction

    // reference from the requirements (no spurious reads)
    task automatic ref_model(input bit tmode, input int b,
                             output bit ok, output int er, output int rd);
        int p;
        p = poll_reads(tmode, b);
        er = 1; rd = p; ok = 1'b1;
        for (int w = 0; w < NW; w++) begin
            int r;
            r = 0;
            while (er < need[w]) begin
                rd += 3; r++;
                if (r == LIMIT) begin ok = 1'b0; return; end
                er++; rd += p;
            end
            rd += 1;
        end
    endtask

    // bus-cycle generator and memory model
    initial begin
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (req_valid) begin
                int lat;
                logic [15:0] d;
                d = 16'h0000;
                if (!first_seen) begin
                    first_ok   = (req_op == 2'd0) && (req_addr == 0);
                    first_seen = 1'b1;
                end
                case (req_op)
                    2'd0: n_enter++;
                    2'd1: begin
                        if (n_enter == 0) order_bad = 1'b1;
                        if (req_kind != kind_exp) kind_bad = 1'b1;
                        n_erase++; erase_cnt++; busy_left = b_cfg; tog = 1'b0;
                    end
                    2'd2: begin n_exit++; exit_addr = int'(req_addr); end
                    default: begin
                        if (n_erase == 0) order_bad = 1'b1;
                        if (int'(req_addr) < last_rd) addr_bad = 1'b1;
                        last_rd = int'(req_addr);
                        n_read++;
                        if (busy_left > 0) begin
                            d = {8'h00, 1'b0, tog, 6'h00};
                            tog = ~tog; busy_left--;
                        end else if (spur_left > 0) begin
                            d = 16'hFFDF; spur_left--;
                        end else begin
                            d = (erase_cnt >= need[req_addr]) ? 16'hFFFF : 16'h12C3;
                        end
                    end
                endcase
                lat = 1 + int'($urandom % 3);
                repeat (lat) @(negedge clk);
                rsp_data  = d;
                rsp_valid = 1'b1;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    task automatic run_case(input bit tmode, input logic [1:0] kind, input int b,
                            input int spur, input bit exp_ok, input int exp_er,
                            input int exp_rd, input bit poke);
        int t;
        n_enter = 0; n_erase = 0; n_exit = 0; n_read = 0; last_rd = 0; exit_addr = -1;
        first_seen = 0; first_ok = 0; order_bad = 0; kind_bad = 0; addr_bad = 0;
        erase_cnt = 0; busy_left = 0; spur_left = spur; b_cfg = b; kind_exp = kind;
        @(negedge clk);
        poll_toggle = tmode; erase_kind = kind; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && !error, "R1 start clears outcome", int'(busy), 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            erase_kind = ~kind; poll_toggle = ~tmode; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!(done || error) && t < 60000) begin @(negedge clk); t++; end
        chk(done == exp_ok && error == !exp_ok, "R6/R9 outcome", int'(done), int'(exp_ok));
        chk(n_erase == exp_er, "R8 erase count", n_erase, exp_er);
        chk(n_read == exp_rd, "R3/R4/R7 read count", n_read, exp_rd);
        chk(first_ok && n_enter == 1, "R1 first request enter at 0", n_enter, 1);
        chk(!order_bad && !kind_bad, "R2 order and kind", int'(order_bad) + 2 * int'(kind_bad), 0);
        chk(!addr_bad, "R5 read address order", last_rd, LAST);
        chk(n_exit == int'(exp_ok), "R9 exit count", n_exit, int'(exp_ok));
        if (exp_ok) chk(exit_addr == LAST, "R6 exit address", exit_addr, LAST);
        repeat (5) @(negedge clk);
        chk(done == exp_ok && error == !exp_ok && !busy, "R10 outcome held",
            int'(done) * 2 + int'(error), exp_ok ? 2 : 1);
    endtask

    task automatic set_need(input int v);
        for (int w = 0; w < NW; w++) need[w] = v;
    endtask

    initial begin
        bit ok;
        int er, rd;
        void'($urandom(32'd20240611));
        set_need(1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !error && !req_valid, "R1 reset state",
            int'(busy) + int'(done) + int'(error) + int'(req_valid), 0);

        // clean region, data polling, no busy reads
        run_case(1'b0, 2'd0, 0, 0, 1'b1, 1, 1 + NW, 1'b0);
        // toggle polling, odd and even busy lengths (R3)
        run_case(1'b1, 2'd1, 3, 0, 1'b1, 1, 5 + NW, 1'b0);
        run_case(1'b1, 2'd2, 2, 0, 1'b1, 1, 3 + NW, 1'b0);
        run_case(1'b1, 2'd0, 0, 0, 1'b1, 1, 2 + NW, 1'b0);
        // data polling with busy reads (R4)
        run_case(1'b0, 2'd1, 4, 0, 1'b1, 1, 5 + NW, 1'b0);
        // two spurious check reads then a clean one: pass, no retry (R7)
        run_case(1'b0, 2'd0, 1, 3, 1'b1, 1, 2 + 3 + (NW - 1), 1'b0);
        // three spurious check reads: confirmed rejection, one re-erase (R7, R8)
        run_case(1'b0, 2'd2, 1, 4, 1'b1, 2, 2 + 3 + 2 + NW, 1'b0);
        // word never erases: error after LIMIT rejections (R9)
        set_need(1); need[0] = 1000;
        ref_model(1'b0, 0, ok, er, rd);
        run_case(1'b0, 2'd1, 0, 0, ok, er, rd, 1'b0);
        // retry count is per word: 119 rejections over two words still finish (R8)
        set_need(120); need[0] = 60;
        ref_model(1'b1, 1, ok, er, rd);
        run_case(1'b1, 2'd0, 1, 0, ok, er, rd, 1'b0);
        // start while busy ignored (R10)
        for (int w = 0; w < NW; w++) need[w] = 1 + w / 3;
        ref_model(1'b0, 2, ok, er, rd);
        run_case(1'b0, 2'd2, 2, 0, ok, er, rd, 1'b1);
        // random regions
        for (int i = 0; i < 10; i++) begin
            bit tm;
            int b;
            logic [1:0] k;
            tm = 1'($urandom % 2);
            b  = int'($urandom % 5);
            k  = 2'($urandom % 3);
            for (int w = 0; w < NW; w++) need[w] = 1 + int'($urandom % 5);
            ref_model(tm, b, ok, er, rd);
            run_case(tm, k, b, 0, ok, er, rd, 1'($urandom % 2));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule